// File: doc/BRIEF.md
# Bitmap Block Allocator for a Shared Buffer RAM

This block manages the space of a 16 KB data buffer RAM. It does not hold the RAM. The RAM is split into equal blocks, and a bitmap keeps one bit per block; a set bit means the block is in use. The bitmap is made of 32-bit words, and the number of words is a parameter that fixes the block size.

A requester presents a byte count and gets back either a byte offset into the RAM or the out-of-memory code 16384. The search is aligned first fit. The request is rounded up to a power-of-two run of blocks, and candidate positions are tried in steps of that run, so a region never crosses a bitmap word. Words are tried in ascending order, and each candidate takes one clock.

A release presents the offset and byte count of a region and clears the matching bits in one clock. Allocation and release share one valid/ready handshake each. Both are refused while a search runs, and a pending allocation wins over a release in the same cycle.

Top module: `bmalloc_top`

## Requirements
- R1: The block size is RAM_BYTES / 32 / MAP_WORDS bytes (256 with the defaults of 16384 and 2). A request of S bytes occupies ceil(S / block size) contiguous blocks, and every returned offset is a multiple of the block size.
- R2: A request of zero bytes, or of more than 32 blocks, returns offset 16384 with resultValid in the cycle right after acceptance, and busy stays low.
- R3: The stride is the smallest power of two (1, 2, 4, 8, 16 or 32) not below the block count. Candidates are bit positions 0, stride, 2*stride and so on in word 0, then the same positions in word 1 and so on. The first candidate whose bits are all clear wins, and the offset is (word*32 + bit) * block size.
- R4: On success the winning bits are set, so later requests do not get any block of that region.
- R5: When no candidate is free, the result is offset 16384 after every candidate has been tried.
- R6: Each candidate takes one cycle. When candidate k (counting from 1) is the last one tried, resultValid pulses for one cycle k cycles after acceptance. busy is high from acceptance until that pulse.
- R7: allocReady is low while busy. freeReady is low while busy, and also whenever allocValid is high, because an allocation has priority.
- R8: An accepted release clears min(ceil(size / block size), 32) bits, starting at bit (offset / block size) mod 32 of word (offset / block size) / 32. Bits past bit 31 are dropped. The release gives no result pulse and is seen by a request accepted in the next cycle.
- R9: Releasing blocks that are already free leaves them free and has no other effect.
- R10: A synchronous reset clears the whole bitmap and leaves busy and resultValid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| allocValid | input | 1 | Allocation request present |
| allocSize | input | 16 | Requested size in bytes |
| allocReady | output | 1 | Allocation request accepted this cycle when valid |
| freeValid | input | 1 | Release request present |
| freeOffset | input | 15 | Byte offset of the region to release |
| freeSize | input | 16 | Byte size of the region to release |
| freeReady | output | 1 | Release accepted this cycle when valid |
| busy | output | 1 | Search in progress |
| resultValid | output | 1 | One-cycle pulse carrying an allocation result |
| resultOffset | output | 15 | Allocated byte offset, or 16384 for out of memory |

## Verification
An allocation result is due k cycles after the accepting edge, where k is the 1-based index of the last candidate tried. A rejected size gives k = 0: the pulse appears right after acceptance. A release takes effect at its accepting edge and produces no pulse. The bench keeps a behavioural bitmap that returns the expected offset together with k. At every falling edge between acceptance and cycle k it checks that busy is high, that resultValid is low and that both ready outputs are low. It then checks the pulse and the offset in exactly cycle k, and checks that resultValid is low again on the next falling edge.

// File: rtl/bmalloc_pkg.sv
package bmalloc_pkg;

  typedef enum logic {ST_IDLE, ST_SEARCH} state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request geometry, rewind search
    logic advance;  // step to next candidate
    logic commit;   // claim current candidate, report offset
    logic fail;     // report out-of-memory
    logic relBits;  // apply a release
  } strobe_t;

  // contiguous run of n ones, n in 0..32
  function automatic logic [31:0] maskOf(input logic [5:0] n);
    logic [31:0] m;
    if (n >= 6'd32) m = '1;
    else m = (32'd1 << n[4:0]) - 32'd1;
    return m;
  endfunction

  // smallest power of two not below n (n in 1..32)
  function automatic logic [5:0] strideOf(input logic [5:0] n);
    logic [5:0] s;
    s = 6'd32;
    for (int i = 5; i >= 0; i--) begin
      if ((7'd1 << i) >= {1'b0, n}) s = 6'(7'd1 << i);
    end
    return s;
  endfunction

endpackage

// File: rtl/bmalloc_datapath.sv
module bmalloc_datapath
  import bmalloc_pkg::*;
#(
  parameter int MAP_WORDS = 2,
  parameter int RAM_BYTES = 16384,
  parameter int SIZE_W    = 16,
  parameter int OFF_W     = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [SIZE_W-1:0] allocSize,
  input  logic [OFF_W-1:0]  freeOffset,
  input  logic [SIZE_W-1:0] freeSize,
  output logic              reqBad,
  output logic              candHit,
  output logic              candLast,
  output logic              resultValid,
  output logic [OFF_W-1:0]  resultOffset
);

  localparam int BLOCK_BYTES = RAM_BYTES / 32 / MAP_WORDS;
  localparam int BLK_SH      = $clog2(BLOCK_BYTES);
  localparam int WIDX_W      = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1;
  localparam int CNT_W       = SIZE_W + 1;
  localparam int IDX_W       = OFF_W - BLK_SH;

  logic [31:0] bitmap [MAP_WORDS];

  // request geometry
  logic [CNT_W-1:0] reqBlocks;
  assign reqBlocks = ({1'b0, allocSize} + CNT_W'(BLOCK_BYTES - 1)) >> BLK_SH;
  assign reqBad    = (allocSize == '0) || (reqBlocks > CNT_W'(32));

  logic [31:0]       reqMask;
  logic [5:0]        reqStride;
  logic [WIDX_W-1:0] curWord;
  logic [5:0]        curPos;

  // current candidate
  logic [31:0] candMask;
  logic [6:0]  nextPos;
  logic        wordEnd;
  assign candMask = reqMask << curPos[4:0];
  assign candHit  = (bitmap[curWord] & candMask) == '0;
  assign nextPos  = {1'b0, curPos} + {1'b0, reqStride};
  assign wordEnd  = nextPos >= 7'd32;
  assign candLast = wordEnd && (curWord == WIDX_W'(MAP_WORDS - 1));

  // release geometry
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] freeWordSel;
  logic [CNT_W-1:0] freeBlocks;
  logic [5:0]       freeCnt;
  logic [31:0]      freeMask;
  assign freeIdx     = freeOffset[OFF_W-1:BLK_SH];
  assign freeWordSel = freeIdx >> 5;
  assign freeBlocks  = ({1'b0, freeSize} + CNT_W'(BLOCK_BYTES - 1)) >> BLK_SH;
  assign freeCnt     = (freeBlocks >= CNT_W'(32)) ? 6'd32 : freeBlocks[5:0];
  assign freeMask    = maskOf(freeCnt) << freeIdx[4:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      reqMask   <= '0;
      reqStride <= 6'd1;
      curWord   <= '0;
      curPos    <= '0;
    end else if (stb.load) begin
      reqMask   <= maskOf(reqBlocks[5:0]);
      reqStride <= strideOf(reqBlocks[5:0]);
      curWord   <= '0;
      curPos    <= '0;
    end else if (stb.advance) begin
      if (wordEnd) begin
        curPos  <= '0;
        curWord <= curWord + WIDX_W'(1);
      end else begin
        curPos  <= nextPos[5:0];
      end
    end
  end

  // one register word per bitmap word
  for (genvar w = 0; w < MAP_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        bitmap[w] <= '0;
      end else if (stb.commit && (curWord == WIDX_W'(w))) begin
        bitmap[w] <= bitmap[w] | candMask;
      end else if (stb.relBits && (freeWordSel == IDX_W'(w))) begin
        bitmap[w] <= bitmap[w] & ~freeMask;
      end
    end
  end

  logic [WIDX_W+4:0] blkIdx;
  assign blkIdx = {curWord, curPos[4:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      resultValid  <= 1'b0;
      resultOffset <= '0;
    end else begin
      resultValid <= stb.commit | stb.fail;
      if (stb.commit) resultOffset <= OFF_W'(blkIdx) << BLK_SH;
      else if (stb.fail) resultOffset <= OFF_W'(RAM_BYTES);
    end
  end

endmodule

// File: rtl/bmalloc_ctrl.sv
module bmalloc_ctrl
  import bmalloc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    allocValid,
  input  logic    freeValid,
  input  logic    reqBad,
  input  logic    candHit,
  input  logic    candLast,
  output strobe_t stb,
  output logic    allocReady,
  output logic    freeReady,
  output logic    busy
);

  state_t state, stateNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (allocValid) begin
          stb.load = 1'b1;
          if (reqBad) stb.fail = 1'b1;
          else stateNext = ST_SEARCH;
        end else if (freeValid) begin
          stb.relBits = 1'b1;
        end
      end
      ST_SEARCH: begin
        if (candHit) begin
          stb.commit = 1'b1;
          stateNext  = ST_IDLE;
        end else if (candLast) begin
          stb.fail  = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stb.advance = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else state <= stateNext;
  end

  assign busy       = (state == ST_SEARCH);
  assign allocReady = !busy;
  assign freeReady  = !busy && !allocValid;

endmodule

// File: rtl/bmalloc_top.sv
module bmalloc_top
  import bmalloc_pkg::*;
#(
  parameter int MAP_WORDS = 2,
  parameter int RAM_BYTES = 16384,
  parameter int SIZE_W    = 16,
  parameter int OFF_W     = $clog2(RAM_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              allocValid,
  input  logic [SIZE_W-1:0] allocSize,
  output logic              allocReady,
  input  logic              freeValid,
  input  logic [OFF_W-1:0]  freeOffset,
  input  logic [SIZE_W-1:0] freeSize,
  output logic              freeReady,
  output logic              busy,
  output logic              resultValid,
  output logic [OFF_W-1:0]  resultOffset
);

  strobe_t stb;
  logic    reqBad;
  logic    candHit;
  logic    candLast;

  bmalloc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .allocValid (allocValid),
    .freeValid  (freeValid),
    .reqBad     (reqBad),
    .candHit    (candHit),
    .candLast   (candLast),
    .stb        (stb),
    .allocReady (allocReady),
    .freeReady  (freeReady),
    .busy       (busy)
  );

  bmalloc_datapath #(
    .MAP_WORDS (MAP_WORDS),
    .RAM_BYTES (RAM_BYTES),
    .SIZE_W    (SIZE_W),
    .OFF_W     (OFF_W)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .allocSize    (allocSize),
    .freeOffset   (freeOffset),
    .freeSize     (freeSize),
    .reqBad       (reqBad),
    .candHit      (candHit),
    .candLast     (candLast),
    .resultValid  (resultValid),
    .resultOffset (resultOffset)
  );

endmodule

// File: rtl/bmalloc_checker.sv
module bmalloc_checker #(
  parameter int MAP_WORDS = 2,
  parameter int RAM_BYTES = 16384,
  parameter int SIZE_W    = 16,
  parameter int OFF_W     = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              allocValid,
  input logic [SIZE_W-1:0] allocSize,
  input logic              allocReady,
  input logic              freeValid,
  input logic              freeReady,
  input logic              busy,
  input logic              resultValid,
  input logic [OFF_W-1:0]  resultOffset
);

  localparam int BLOCK_BYTES = RAM_BYTES / 32 / MAP_WORDS;
  localparam int BLK_SH      = $clog2(BLOCK_BYTES);

  AST_BLOCK_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> (resultOffset[BLK_SH-1:0] == '0)); // R1

  AST_ZERO_SIZE_FAILS: assert property (@(posedge clk) disable iff (rst)
    (allocValid && allocReady && allocSize == '0) |=>
      (resultValid && resultOffset == OFF_W'(RAM_BYTES) && !busy)); // R2

  AST_OOM_CODE_EXACT: assert property (@(posedge clk) disable iff (rst)
    (resultValid && resultOffset >= OFF_W'(RAM_BYTES)) |->
      (resultOffset == OFF_W'(RAM_BYTES))); // R5

  AST_SEARCH_ENDS_WITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> resultValid); // R6

  AST_BUSY_FROM_REQUEST: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(allocValid && allocReady)); // R7

  AST_RELEASE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (freeValid && freeReady) |=> (!resultValid && !busy)); // R8

endmodule

bind bmalloc_top bmalloc_checker #(
  .MAP_WORDS (MAP_WORDS),
  .RAM_BYTES (RAM_BYTES),
  .SIZE_W    (SIZE_W),
  .OFF_W     (OFF_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .allocValid   (allocValid),
  .allocSize    (allocSize),
  .allocReady   (allocReady),
  .freeValid    (freeValid),
  .freeReady    (freeReady),
  .busy         (busy),
  .resultValid  (resultValid),
  .resultOffset (resultOffset)
);

// File: tb/bmalloc_top_tb.sv
module bmalloc_top_tb;

  localparam int MAP_WORDS = 2;
  localparam int RAM_BYTES = 16384;
  localparam int SIZE_W    = 16;
  localparam int OFF_W     = 15;
  localparam int BB        = RAM_BYTES / 32 / MAP_WORDS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              allocValid = 1'b0;
  logic [SIZE_W-1:0] allocSize = '0;
  logic              allocReady;
  logic              freeValid = 1'b0;
  logic [OFF_W-1:0]  freeOffset = '0;
  logic [SIZE_W-1:0] freeSize = '0;
  logic              freeReady;
  logic              busy;
  logic              resultValid;
  logic [OFF_W-1:0]  resultOffset;

  always #2 clk = ~clk;

  bmalloc_top #(.MAP_WORDS(MAP_WORDS), .RAM_BYTES(RAM_BYTES),
                .SIZE_W(SIZE_W), .OFF_W(OFF_W)) u_dut (
    .clk(clk), .rst(rst),
    .allocValid(allocValid), .allocSize(allocSize), .allocReady(allocReady),
    .freeValid(freeValid), .freeOffset(freeOffset), .freeSize(freeSize),
    .freeReady(freeReady), .busy(busy),
    .resultValid(resultValid), .resultOffset(resultOffset)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [MAP_WORDS];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void modelClear();
    for (int w = 0; w < MAP_WORDS; w++) mdl[w] = '0;
  endfunction

  // returns expected offset and number of candidates tried (0 = rejected size)
  function automatic void modelAlloc(input int size, output int off, output int k);
    int blocks;
    int stride;
    logic [31:0] m;
    blocks = (size + BB - 1) / BB;
    off = RAM_BYTES;
    k = 0;
    if (size == 0 || blocks > 32) return;
    stride = 1;
    while (stride < blocks) stride = stride * 2;
    m = (blocks == 32) ? 32'hFFFF_FFFF : ((32'd1 << blocks) - 32'd1);
    for (int w = 0; w < MAP_WORDS; w++) begin
      for (int p = 0; p < 32; p += stride) begin
        k++;
        if ((mdl[w] & (m << p)) == 0) begin
          mdl[w] = mdl[w] | (m << p);
          off = (w * 32 + p) * BB;
          return;
        end
      end
    end
  endfunction

  function automatic void modelFree(input int off, input int size);
    int blocks;
    int idx;
    logic [31:0] m;
    blocks = (size + BB - 1) / BB;
    if (blocks > 32) blocks = 32;
    idx = off / BB;
    m = (blocks == 32) ? 32'hFFFF_FFFF : ((32'd1 << blocks) - 32'd1);
    m = m << (idx % 32);
    if (idx / 32 < MAP_WORDS) mdl[idx / 32] = mdl[idx / 32] & ~m;
  endfunction

  task automatic doAlloc(input int size, input string req, output int got);
    int eOff;
    int eK;
    @(negedge clk);
    chk(resultValid == 1'b0, {req, " idle before request"}, resultValid, 0);
    chk(allocReady == 1'b1, {req, " R7 allocReady idle"}, allocReady, 1);
    allocValid = 1'b1;
    allocSize  = SIZE_W'(size);
    modelAlloc(size, eOff, eK);
    @(negedge clk);
    allocValid = 1'b0;
    for (int c = 0; c <= eK; c++) begin
      if (c > 0) @(negedge clk);
      if (c < eK) begin
        chk(busy == 1'b1 && resultValid == 1'b0, {req, " R6 searching"},
            {busy, resultValid}, 2);
        chk(allocReady == 1'b0 && freeReady == 1'b0, {req, " R7 ready low while busy"},
            {allocReady, freeReady}, 0);
      end else begin
        chk(resultValid == 1'b1, {req, " R6 result pulse"}, resultValid, 1);
        chk(int'(resultOffset) == eOff, {req, " offset"}, resultOffset, eOff);
        chk(busy == 1'b0, {req, " R6 busy released"}, busy, 0);
      end
    end
    got = int'(resultOffset);
  endtask

  task automatic doFree(input int off, input int size, input string req);
    @(negedge clk);
    chk(freeReady == 1'b1, {req, " R7 freeReady idle"}, freeReady, 1);
    freeValid  = 1'b1;
    freeOffset = OFF_W'(off);
    freeSize   = SIZE_W'(size);
    modelFree(off, size);
    @(negedge clk);
    freeValid = 1'b0;
    chk(resultValid == 1'b0 && busy == 1'b0, {req, " R8 release gives no pulse"},
        {busy, resultValid}, 0);
  endtask

  int got;
  int q_off[$];
  int q_size[$];
  int seed;
  int sz;

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && resultValid == 1'b0, "R10 reset outputs", {busy, resultValid}, 0);
    chk(allocReady == 1'b1 && freeReady == 1'b1, "R10 R7 ready after reset",
        {allocReady, freeReady}, 3);
    rst = 1'b0;

    // rejected sizes
    doAlloc(0, "R2 zero size", got);
    doAlloc(9000, "R2 over 32 blocks", got);
    chk(got == RAM_BYTES, "R2 oom code", got, RAM_BYTES);

    // first fit, strides
    doAlloc(100, "R1 R3 one block", got);
    chk(got == 0, "R3 first position", got, 0);
    doAlloc(256, "R4 next block", got);
    chk(got == 256, "R4 skip used block", got, 256);
    doAlloc(600, "R3 stride 4", got);
    chk(got == 1024, "R3 aligned to stride", got, 1024);
    doAlloc(8192, "R3 full word", got);
    chk(got == 8192, "R3 second word", got, 8192);
    doAlloc(8192, "R5 no room", got);
    chk(got == RAM_BYTES, "R5 oom after search", got, RAM_BYTES);

    // release then reuse
    doFree(256, 256, "R8 release block 1");
    doAlloc(200, "R8 reuse released", got);
    chk(got == 256, "R8 reuse offset", got, 256);

    // release of already-free blocks
    doFree(7 * 256, 256, "R9 release free block");
    doFree(20 * 256, 1024, "R9 release free run");
    doAlloc(256, "R9 state unchanged", got);
    chk(got == 512, "R9 lowest free block", got, 512);

    // release a whole word with over-long size, bits past word dropped
    doFree(8192, 12000, "R8 capped release");
    doAlloc(4096, "R3 stride 16", got);
    chk(got == 4096, "R3 stride 16 offset", got, 4096);
    doAlloc(8192, "R8 word free again", got);
    chk(got == 8192, "R8 word1 reusable", got, 8192);

    // allocation wins over a simultaneous release
    @(negedge clk);
    freeValid  = 1'b1;
    freeOffset = OFF_W'(4096);
    freeSize   = SIZE_W'(4096);
    doAlloc(300, "R7 alloc priority", got);
    chk(freeReady == 1'b1, "R7 release accepted after search", freeReady, 1);
    modelFree(4096, 4096);
    @(negedge clk);
    freeValid = 1'b0;
    doAlloc(4096, "R7 release applied", got);
    chk(got == 4096, "R7 release applied offset", got, 4096);

    // mixed traffic
    seed = 12345;
    for (int i = 0; i < 60; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7FFF_FFFF;
      sz = (i % 13 == 5) ? 0 : 1 + (seed % 5000);
      doAlloc(sz, "R3 R4 R5 mixed", got);
      if (got < RAM_BYTES) begin
        q_off.push_back(got);
        q_size.push_back(sz);
      end
      if (q_off.size() > 4 || (i % 4 == 3 && q_off.size() > 0)) begin
        doFree(q_off.pop_front(), q_size.pop_front(), "R8 mixed release");
      end
    end

    // reset clears the bitmap
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    modelClear();
    doAlloc(8192, "R10 bitmap cleared", got);
    chk(got == 0, "R10 word 0 free after reset", got, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule